// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Tile

This block multiplies a stream of signed 8-bit activation rows by an N×N weight tile that stays resident in a grid of multiply-accumulate cells. Weights are written one at a time into a shadow register inside each cell. A swap request then moves the whole shadow set into the active registers in a single cycle. Because of the shadow set, the next tile's weights can be written while the current tile is still computing. After a swap, activation rows enter at one per cycle. Each row is skewed across the reduction lanes, partial sums travel down the columns, and the column results are re-aligned at the bottom.

The N column sums for each row go into an accumulator buffer of 32-bit entries, at the row address that travels with the activation. A first flag that also travels with the row chooses between overwriting the entry and adding to it. A reduction dimension longer than N is handled as a series of weight tiles: the first tile writes, and each later tile adds. A read port returns one full accumulator row, one cycle after the request. Streaming more rows per weight tile gives more reuse of each loaded tile.

Top module: `ws_tile_top`

## Requirements
- R1: The active weights change only in the cycle a swap is taken. Writing the shadow set has no effect on the results of rows streamed before the next swap.
- R2: While `act_ready` is high, one activation row is accepted on every cycle that `act_valid` is high, with no bubbles between rows.
- R3: When `swap_ack` is high at a rising edge, every shadow weight is copied into its active register on that edge.
- R4: `swap_ack` stays low until all N×N shadow positions have been written since the previous swap. The shadow position for reduction lane k and output column j is at address k·N+j.
- R5: While `swap_req` is high, `act_ready` is low. The swap is taken only after every accepted row has been written into the accumulator, so those rows use the old weights.
- R6: For a row with lane values x[k], lane k at `act_row[8k+7:8k]`, column j receives the signed sum over k of x[k]·W[k][j]. The sum is computed to 32 bits, and column j is returned at `rd_data[32j+31:32j]`.
- R7: A row accepted with `act_first`=1 overwrites its accumulator entry. A row accepted with `act_first`=0 adds its column sums to the entry already stored.
- R8: A read request on `rd_en` returns `rd_data` with `rd_valid` high in the following cycle.
- R9: After reset, `act_ready`, `swap_ack` and `rd_valid` are low, and `act_ready` stays low until the first swap has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wld_en | input | 1 | Shadow weight write strobe |
| wld_addr | input | $clog2(N*N) | Shadow position, k·N+j |
| wld_data | input | 8 | Signed weight value |
| swap_req | input | 1 | Request to move shadow weights into the active registers |
| swap_ack | output | 1 | Swap is taken at the coming edge |
| act_valid | input | 1 | Activation row valid |
| act_ready | output | 1 | Activation row can be accepted |
| act_row | input | 8·N | Signed activation lanes, lane k at bits 8k+7:8k |
| act_addr | input | $clog2(DEPTH) | Accumulator row for this activation row |
| act_first | input | 1 | Overwrite (1) or add (0) into the accumulator |
| rd_en | input | 1 | Accumulator read request |
| rd_addr | input | $clog2(DEPTH) | Accumulator row to read |
| rd_data | output | 32·N | Accumulated column sums, column j at bits 32j+31:32j |
| rd_valid | output | 1 | `rd_data` is valid |

## Verification
Several properties are checked on every cycle. The active weight set is held steady between swaps and matches the shadow set immediately after a swap. A swap is never taken while an accepted row has not yet reached the accumulator. The shadow-loaded state clears after each swap. Reads answer in the next cycle. The bench scenarios cover what only end-to-end values can show: the signed products and sums against a reference matrix product, the overwrite-then-add behaviour across two reduction tiles, extreme int8 operands, and the fact that weights loaded during streaming leave the in-flight results untouched.

// File: rtl/ws_pkg.sv
// Shared widths and element types for the weight-stationary tile.
// Assumes signed int8 operands and 32-bit accumulation.
package ws_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ACC_W  = 32;

    typedef logic signed [DATA_W-1:0] act_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/ws_pe.sv
// One processing cell. It holds a shadow weight and an active weight,
// forwards its activation to the right and adds its product to the
// partial sum passing downward. Assumes the swap is issued only while
// no useful data is in flight.
module ws_pe
    import ws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shd_we,
    input  act_t shd_wdata,
    input  logic swap,
    input  act_t a_in,
    input  acc_t p_in,
    output act_t a_out,
    output acc_t p_out,
    output act_t w_act,
    output act_t w_shd
);
    acc_t prod;

    // Signed product, extended to accumulator width
    assign prod = acc_t'(a_in) * acc_t'(w_act);

    // Shadow weight capture from the load port
    always_ff @(posedge clk) begin
        if (!rst_n)      w_shd <= '0;
        else if (shd_we) w_shd <= shd_wdata;
    end

    // Active weight update, only on a swap
    always_ff @(posedge clk) begin
        if (!rst_n)    w_act <= '0;
        else if (swap) w_act <= w_shd;
    end

    // Pass activation right, partial sum down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out <= '0;
            p_out <= '0;
        end else begin
            a_out <= a_in;
            p_out <= p_in + prod;
        end
    end
endmodule

// File: rtl/ws_array.sv
// N x N grid of cells. Input lane k is delayed by k cycles before it
// enters row k. Output column j is delayed by N-1-j cycles, so that all
// column sums of one row leave together, 2N-1 cycles after the row enters.
module ws_array
    import ws_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N*DATA_W-1:0]          row_in,
    input  logic [N*N-1:0]               shd_we,
    input  act_t                         shd_wdata,
    input  logic                         swap,
    output logic [N-1:0][ACC_W-1:0]      col_out,
    output logic [N*N-1:0][DATA_W-1:0]   w_act_all,
    output logic [N*N-1:0][DATA_W-1:0]   w_shd_all
);
    act_t lane  [N];
    act_t a_bus [N][N+1];
    acc_t p_bus [N+1][N];

    for (genvar k = 0; k < N; k++) begin : g_skew
        if (k == 0) begin : g_direct
            assign lane[k] = act_t'(row_in[k*DATA_W +: DATA_W]);
        end else begin : g_dly
            act_t sr [k];
            // Delay lane k by k cycles
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < k; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= act_t'(row_in[k*DATA_W +: DATA_W]);
                    for (int i = 1; i < k; i++) sr[i] <= sr[i-1];
                end
            end
            assign lane[k] = sr[k-1];
        end
        assign a_bus[k][0] = lane[k];
    end

    for (genvar j = 0; j < N; j++) begin : g_top
        assign p_bus[0][j] = '0;
    end

    for (genvar k = 0; k < N; k++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            act_t wa, ws;
            ws_pe u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .shd_we   (shd_we[k*N+j]),
                .shd_wdata(shd_wdata),
                .swap     (swap),
                .a_in     (a_bus[k][j]),
                .p_in     (p_bus[k][j]),
                .a_out    (a_bus[k][j+1]),
                .p_out    (p_bus[k+1][j]),
                .w_act    (wa),
                .w_shd    (ws)
            );
            assign w_act_all[k*N+j] = wa;
            assign w_shd_all[k*N+j] = ws;
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_deskew
        if (j == N-1) begin : g_direct
            assign col_out[j] = p_bus[N][j];
        end else begin : g_dly
            acc_t dq [N-1-j];
            // Delay column j by N-1-j cycles
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < N-1-j; i++) dq[i] <= '0;
                end else begin
                    dq[0] <= p_bus[N][j];
                    for (int i = 1; i < N-1-j; i++) dq[i] <= dq[i-1];
                end
            end
            assign col_out[j] = dq[N-2-j];
        end
    end
endmodule

// File: rtl/ws_psum_acc.sv
// Partial-sum buffer of DEPTH rows, N columns of 32 bits each.
// A write either overwrites its row or adds to it. Reads are registered
// and return one cycle later. Assumes a read does not target the row
// being written in the same cycle.
module ws_psum_acc
    import ws_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AAW  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_first,
    input  logic [AAW-1:0]          wr_addr,
    input  logic [N-1:0][ACC_W-1:0] wr_cols,
    input  logic                    rd_en,
    input  logic [AAW-1:0]          rd_addr,
    output logic [N-1:0][ACC_W-1:0] rd_data,
    output logic                    rd_valid
);
    logic [N-1:0][ACC_W-1:0] mem [DEPTH];

    // Overwrite or accumulate the addressed row
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int j = 0; j < N; j++) begin
                mem[wr_addr][j] <= wr_first ? wr_cols[j] : mem[wr_addr][j] + wr_cols[j];
            end
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // Read valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end
endmodule

// File: rtl/ws_tile_top.sv
// Weight-stationary tile: shadow-load control, swap gating, the row
// pipeline with its tags, and the accumulator. A swap is taken only when
// the shadow set is complete and no accepted row is still in flight.
module ws_tile_top
    import ws_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AAW  = $clog2(DEPTH),
    localparam int unsigned WA   = $clog2(N*N),
    localparam int unsigned LAT  = 2*N-1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wld_en,
    input  logic [WA-1:0]         wld_addr,
    input  logic [DATA_W-1:0]     wld_data,
    input  logic                  swap_req,
    output logic                  swap_ack,
    input  logic                  act_valid,
    output logic                  act_ready,
    input  logic [N*DATA_W-1:0]   act_row,
    input  logic [AAW-1:0]        act_addr,
    input  logic                  act_first,
    input  logic                  rd_en,
    input  logic [AAW-1:0]        rd_addr,
    output logic [N*ACC_W-1:0]    rd_data,
    output logic                  rd_valid
);
    logic [N*N-1:0]            hit;
    logic [N*N-1:0]            loaded;
    logic                      shadow_full;
    logic                      wt_live;
    logic                      busy;
    logic                      accept;
    logic                      in_vld, in_first;
    logic [AAW-1:0]            in_addr;
    logic [N*DATA_W-1:0]       in_row;
    logic [LAT-1:0]            m_vld, m_first;
    logic [AAW-1:0]            m_addr [LAT];
    logic                      wr_en;
    logic [N-1:0][ACC_W-1:0]   col_out;
    logic [N-1:0][ACC_W-1:0]   rd_q;
    logic [N*N-1:0][DATA_W-1:0] w_act_all, w_shd_all;

    for (genvar i = 0; i < N*N; i++) begin : g_dec
        assign hit[i] = wld_en && (wld_addr == WA'(i));
    end

    assign shadow_full = &loaded;
    assign busy        = in_vld | (|m_vld);
    assign swap_ack    = swap_req & shadow_full & ~busy;
    assign act_ready   = wt_live & ~swap_req;
    assign accept      = act_valid & act_ready;
    assign wr_en       = m_vld[LAT-1];

    // Track which shadow positions hold fresh weights
    always_ff @(posedge clk) begin
        if (!rst_n) loaded <= '0;
        else        loaded <= (swap_ack ? '0 : loaded) | hit;
    end

    // Active weights become usable after the first swap
    always_ff @(posedge clk) begin
        if (!rst_n)        wt_live <= 1'b0;
        else if (swap_ack) wt_live <= 1'b1;
    end

    // Input stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_vld   <= 1'b0;
            in_first <= 1'b0;
            in_addr  <= '0;
            in_row   <= '0;
        end else begin
            in_vld   <= accept;
            in_first <= act_first;
            in_addr  <= act_addr;
            in_row   <= accept ? act_row : '0;
        end
    end

    // Row tags travel alongside the array latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_vld   <= '0;
            m_first <= '0;
            for (int i = 0; i < LAT; i++) m_addr[i] <= '0;
        end else begin
            m_vld   <= {m_vld[LAT-2:0], in_vld};
            m_first <= {m_first[LAT-2:0], in_first};
            m_addr[0] <= in_addr;
            for (int i = 1; i < LAT; i++) m_addr[i] <= m_addr[i-1];
        end
    end

    ws_array #(.N(N)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_in   (in_row),
        .shd_we   (hit),
        .shd_wdata(act_t'(wld_data)),
        .swap     (swap_ack),
        .col_out  (col_out),
        .w_act_all(w_act_all),
        .w_shd_all(w_shd_all)
    );

    ws_psum_acc #(.N(N), .DEPTH(DEPTH)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_first(m_first[LAT-1]),
        .wr_addr (m_addr[LAT-1]),
        .wr_cols (col_out),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_q),
        .rd_valid(rd_valid)
    );

    assign rd_data = rd_q;
endmodule

// File: rtl/ws_tile_chk.sv
// Property checker for ws_tile_top. It keeps its own count of rows
// between acceptance and accumulator write, and checks weight handling,
// swap gating and read latency against it.
module ws_tile_chk #(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  accept,
    input logic                  wr_en,
    input logic                  swap_ack,
    input logic                  wld_en,
    input logic                  shadow_full,
    input logic                  rd_en,
    input logic                  rd_valid,
    input logic [N*N*DW-1:0]     w_act_all,
    input logic [N*N*DW-1:0]     w_shd_all
);
    localparam int unsigned CW = $clog2(2*N+2) + 1;
    logic [CW-1:0] in_flight;

    // Count rows accepted but not yet written
    always_ff @(posedge clk) begin
        if (!rst_n) in_flight <= '0;
        else        in_flight <= in_flight + CW'(accept) - CW'(wr_en);
    end

    p_hold_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_ack |=> $stable(w_act_all));

    p_flight_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= CW'(2*N));

    p_swap_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |=> (w_act_all == $past(w_shd_all)));

    p_reload_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_ack && !wld_en) |=> !shadow_full);

    p_drained_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> (in_flight == '0));

    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

bind ws_tile_top ws_tile_chk #(.N(N), .DW(ws_pkg::DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .wr_en      (wr_en),
    .swap_ack   (swap_ack),
    .wld_en     (wld_en),
    .shadow_full(shadow_full),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .w_act_all  (w_act_all),
    .w_shd_all  (w_shd_all)
);

// File: tb/ws_tile_top_tb.sv
// Directed bench: each task drives one scenario and checks its results
// against a matrix product computed here.
module ws_tile_top_tb;
    localparam int N     = 4;
    localparam int DEPTH = 16;
    localparam int AAW   = $clog2(DEPTH);
    localparam int WA    = $clog2(N*N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wld_en = 1'b0;
    logic [WA-1:0] wld_addr = '0;
    logic [7:0] wld_data = '0;
    logic swap_req = 1'b0;
    logic swap_ack;
    logic act_valid = 1'b0;
    logic act_ready;
    logic [N*8-1:0] act_row = '0;
    logic [AAW-1:0] act_addr = '0;
    logic act_first = 1'b0;
    logic rd_en = 1'b0;
    logic [AAW-1:0] rd_addr = '0;
    logic [N*32-1:0] rd_data;
    logic rd_valid;

    int checks = 0;
    int errors = 0;
    int wt [2*N][N];
    int am [DEPTH][2*N];

    ws_tile_top #(.N(N), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wld_en(wld_en), .wld_addr(wld_addr), .wld_data(wld_data),
        .swap_req(swap_req), .swap_ack(swap_ack),
        .act_valid(act_valid), .act_ready(act_ready), .act_row(act_row),
        .act_addr(act_addr), .act_first(act_first),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int rnd8();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    task automatic load_w(input int k, input int j, input int v);
        wld_en = 1'b1;
        wld_addr = WA'(k*N + j);
        wld_data = 8'(v);
        tick();
        wld_en = 1'b0;
    endtask

    task automatic load_tile(input int kofs);
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) load_w(k, j, wt[kofs+k][j]);
    endtask

    task automatic do_swap(input int limit, output bit got);
        got = 1'b0;
        swap_req = 1'b1;
        for (int c = 0; c < limit && !got; c++) begin
            #1;
            if (swap_ack) got = 1'b1;
            tick();
        end
        swap_req = 1'b0;
    endtask

    // Stream rows 0..cnt-1 using lanes kofs..kofs+N-1; optionally write
    // the next tile's shadow weights (base nxt) one per row at the same time
    task automatic stream(input int kofs, input bit first, input int cnt,
                          input bit ld, input int nxt);
        for (int r = 0; r < cnt; r++) begin
            act_valid = 1'b1;
            act_addr  = AAW'(r);
            act_first = first;
            for (int k = 0; k < N; k++) act_row[k*8 +: 8] = 8'(am[r][kofs+k]);
            if (ld && r < N*N) begin
                wld_en   = 1'b1;
                wld_addr = WA'(r);
                wld_data = 8'(wt[nxt + r/N][r%N]);
            end
            #1;
            chk(act_ready === 1'b1, "R2", "act_ready during back-to-back stream", act_ready, 1);
            tick();
            wld_en = 1'b0;
        end
        act_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (2*N + 2) tick();
    endtask

    // Compare one accumulator row against lanes k0..k1-1 scaled by mul
    task automatic read_check(input int r, input int k0, input int k1,
                              input int mul, input string req);
        int exp_v, got_v, bad;
        bit ok;
        rd_en = 1'b1;
        rd_addr = AAW'(r);
        tick();
        rd_en = 1'b0;
        chk(rd_valid === 1'b1, "R8", "rd_valid one cycle after request", rd_valid, 1);
        ok = 1'b1; bad = 0; exp_v = 0; got_v = 0;
        for (int j = 0; j < N; j++) begin
            int e = 0;
            for (int k = k0; k < k1; k++) e += am[r][k] * wt[k][j];
            e *= mul;
            if ($signed(rd_data[j*32 +: 32]) !== e && ok) begin
                ok = 1'b0; bad = j; exp_v = e; got_v = $signed(rd_data[j*32 +: 32]);
            end
        end
        chk(ok, req, $sformatf("row %0d col %0d", r, bad), got_v, exp_v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(act_ready === 1'b0, "R9", "act_ready after reset", act_ready, 0);
        chk(swap_ack === 1'b0, "R9", "swap_ack after reset", swap_ack, 0);
        chk(rd_valid === 1'b0, "R9", "rd_valid after reset", rd_valid, 0);
    endtask

    task automatic t_blocked_swap();
        bit got;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) wt[k][j] = rnd8();
        for (int i = 0; i < N*N - 1; i++) load_w(i / N, i % N, wt[i/N][i%N]);
        swap_req = 1'b1;
        for (int c = 0; c < 6; c++) begin
            #1;
            chk(swap_ack === 1'b0, "R4", "swap_ack with one position unloaded", swap_ack, 0);
            chk(act_ready === 1'b0, "R9", "act_ready before first swap", act_ready, 0);
            tick();
        end
        swap_req = 1'b0;
        load_w(N-1, N-1, wt[N-1][N-1]);
        do_swap(4, got);
        chk(got, "R3", "swap taken once shadow complete", got, 1);
        #1;
        chk(act_ready === 1'b1, "R9", "act_ready after swap", act_ready, 1);
    endtask

    task automatic t_overwrite_accumulate();
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < N; k++) am[r][k] = rnd8();
        for (int k = 0; k < N; k++) begin
            am[0][k] = -128;
            am[1][k] = 127;
        end
        stream(0, 1'b1, 8, 1'b0, 0);
        drain();
        for (int r = 0; r < 8; r++) read_check(r, 0, N, 1, "R6");
        stream(0, 1'b0, 8, 1'b0, 0);
        drain();
        for (int r = 0; r < 8; r++) read_check(r, 0, N, 2, "R7");
        stream(0, 1'b1, 8, 1'b0, 0);
        drain();
        for (int r = 0; r < 8; r++) read_check(r, 0, N, 1, "R7");
    endtask

    task automatic t_two_tiles();
        bit got;
        for (int k = 0; k < 2*N; k++)
            for (int j = 0; j < N; j++) wt[k][j] = rnd8();
        for (int r = 0; r < DEPTH; r++)
            for (int k = 0; k < 2*N; k++) am[r][k] = rnd8();
        load_tile(0);
        do_swap(2*N + 6, got);
        chk(got, "R3", "swap of first reduction tile", got, 1);
        stream(0, 1'b1, DEPTH, 1'b1, N);
        do_swap(2*N + 6, got);
        chk(got, "R5", "swap after pipeline drained", got, 1);
        stream(N, 1'b0, DEPTH, 1'b0, 0);
        drain();
        for (int r = 0; r < DEPTH; r++) read_check(r, 0, 2*N, 1, "R1");
    endtask

    task automatic t_extremes();
        bit got;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) wt[k][j] = -128;
        for (int k = 0; k < N; k++) begin
            am[0][k] = -128;
            am[1][k] = 127;
        end
        load_tile(0);
        do_swap(2*N + 6, got);
        chk(got, "R3", "swap of extreme tile", got, 1);
        stream(0, 1'b1, 2, 1'b0, 0);
        drain();
        read_check(0, 0, N, 1, "R6");
        read_check(1, 0, N, 1, "R6");
    endtask

    initial begin
        void'($urandom(7));
        t_reset();
        t_blocked_swap();
        t_overwrite_accumulate();
        t_two_tiles();
        t_extremes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule